// File: doc/BRIEF.md
# Packed-Quad Instruction Fetch-Decoder

This block is the front end of a small 16-bit instruction pipeline. It fetches 64-bit instruction quads from a program memory port, keeps the current quad in a buffer, and presents one 16-bit instruction at a time to the execution side. The program counter counts instructions: its two low bits pick the slot inside the buffered quad. A new quad is requested only when the PC leaves the buffered quad, or when a dynamic jump throws the buffer away.

Every presented instruction is split into an opcode and three 4-bit operand fields. It is then decoded through a nested opcode space into a single one-hot operation bit. Primary opcode 5 escapes to a second table selected by operand 2. Entry 15 of that table escapes to a third table selected by operand 1.

The decoder flags illegal words and quads that violate the marker rule. It also computes the next PC for four cases: straight-line flow, conditional skips, relative jumps with a zero-free offset encoding, and register-driven jumps. The execution side acknowledges each instruction with `step`. For skips it supplies the zero test of the register named by operand 2, and for a dynamic jump it supplies the target value.

Top module: `quad_fetch_decoder`

## Requirements
- R1: For the presented word, `opcode` is bits [3:0], `opnd0` bits [7:4], `opnd1` bits [11:8] and `opnd2` bits [15:12]. `imm8` equals `opnd1`*16 + `opnd2`.
- R2: A quad is little-endian: slot s occupies bits [16s+15:16s], and `pc_cur[1:0]` selects the slot. A step whose next PC stays in the same quad (and is not a dynamic jump) issues the next instruction on the following cycle without a memory request. Leaving the quad triggers a fetch of the quad at `pc_next[15:2]`.
- R3: For a legal issued word, exactly one bit of `op_onehot` is set, chosen as follows:
  - bit = opcode, for any opcode other than 5;
  - bit 16 + `opnd2`, when the opcode is 5 and `opnd2` is not 15;
  - bit 32 + `opnd1`, when the opcode is 5 and `opnd2` is 15.
  
  `op_onehot` is zero whenever no legal instruction is presented.
- R4: The all-zero word raises `illegal_ins` with no operation bit set. Opcode 0 with any nonzero operand decodes as the no-op (bit 0).
- R5: Skip-if-zero (opcode 7) and skip-if-nonzero (opcode 8) raise `illegal_ins` when `opnd0` or `opnd1` is nonzero.
- R6: A fetched quad whose bit 0 is 1 raises `illegal_quad`, and none of its instructions is issued (`ins_valid` low).
- R7: For every legal instruction other than a taken skip, a relative jump or a dynamic jump, `pc_next` = `pc_cur` + 1. A step loads `pc_next` into `pc_cur`.
- R8: Opcode 7 with `src_zero`=1, or opcode 8 with `src_zero`=0, gives `pc_next` = `pc_cur` + 2. Otherwise the skip falls through to `pc_cur` + 1.
- R9: Opcode 6 with k = `opnd2` gives `pc_next` = `pc_cur` + 1 + (k − 7) when k > 7, and `pc_cur` + 1 + (k − 9) otherwise. `pc_next` is never `pc_cur` + 1.
- R10: The dynamic jump (operation bit 32: opcode 5, `opnd2`=15, `opnd1`=0) gives `pc_next` = `dyn_target`. The buffered quad is discarded and refetched, even when the target lies in the same quad.
- R11: While `illegal_ins` or `illegal_quad` is high, `step` is ignored and `pc_cur` holds until reset.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen. `ins_valid` is low while a fetch is outstanding.
- R13: After reset, `pc_cur` is 0, `mem_req` is high with `mem_addr` 0, and `ins_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Quad fetch request, held until answered |
| mem_addr | output | 14 | Quad address (PC without slot bits) |
| mem_rdata | input | 64 | Returned quad |
| mem_rvalid | input | 1 | Returned quad valid |
| step | input | 1 | Execution side accepts the presented instruction |
| src_zero | input | 1 | Register named by operand 2 is zero (for skips) |
| dyn_target | input | 16 | Target PC for a dynamic jump |
| ins_valid | output | 1 | An instruction is presented |
| pc_cur | output | 16 | PC of the presented instruction |
| opcode | output | 4 | Primary opcode field |
| opnd0 | output | 4 | Operand 0 field |
| opnd1 | output | 4 | Operand 1 field |
| opnd2 | output | 4 | Operand 2 field |
| imm8 | output | 8 | Constant formed from operand 1 (high) and operand 2 (low) |
| op_onehot | output | 48 | One-hot operation identifier |
| illegal_ins | output | 1 | Presented word is illegal |
| illegal_quad | output | 1 | Buffered quad violates the marker bit |
| pc_next | output | 16 | PC that a step would load |

## Verification
On every cycle, the assertions check four things. `op_onehot` never has more than one bit set, and it is empty on an illegal word. The fetch request holds its address until answered, and no instruction is issued during a fetch or from a marked quad. A step moves the PC to the previously offered `pc_next`, and a trapped decoder never moves its PC. A relative jump never offers the fall-through address. Other behaviour needs the bench's scenarios: the exact escape-table mapping, the signed jump arithmetic at k = 0, 7, 8 and 15, and the skip polarity under both zero-test values. The same goes for the no-refetch rule within a quad, the forced refetch on a same-quad dynamic jump, and the decode of specific illegal words.

// File: rtl/fdq_pkg.sv
// Shared constants and types of the packed-quad fetch-decoder.
// Assumes 4-bit fields, four fields per instruction, four slots per quad.
package fdq_pkg;
    localparam int FIELD_W = 4;
    localparam int INS_W   = 4 * FIELD_W;
    localparam int SLOTS   = 4;
    localparam int QUAD_W  = INS_W * SLOTS;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int TABLE_N = 1 << FIELD_W;
    localparam int LEVELS  = 3;
    localparam int NUM_OPS = LEVELS * TABLE_N;
    localparam int ID_W    = 2 + FIELD_W;

    // primary opcodes the decoder treats specially
    localparam logic [FIELD_W-1:0] OPC_NOP    = 4'd0;
    localparam logic [FIELD_W-1:0] OPC_ESC2   = 4'd5;
    localparam logic [FIELD_W-1:0] OPC_JREL   = 4'd6;
    localparam logic [FIELD_W-1:0] OPC_SKIPZ  = 4'd7;
    localparam logic [FIELD_W-1:0] OPC_SKIPNZ = 4'd8;
    // escape inside the two-operand table, dynamic jump in the one-operand table
    localparam logic [FIELD_W-1:0] SUB2_ESC1  = 4'd15;
    localparam logic [FIELD_W-1:0] SUB1_JD    = 4'd0;

    // level prefixes of the operation identifier
    localparam logic [1:0] LVL_PRI = 2'd0;
    localparam logic [1:0] LVL_TWO = 2'd1;
    localparam logic [1:0] LVL_ONE = 2'd2;

    // relative jump offset encoding
    localparam logic [FIELD_W-1:0] JREL_SPLIT   = 4'd7;
    localparam logic [FIELD_W-1:0] JREL_BIAS_HI = 4'd7;
    localparam logic [FIELD_W-1:0] JREL_BIAS_LO = 4'd9;

    typedef enum logic {FS_WAIT, FS_HAVE} fetch_state_t;
endpackage

// File: rtl/fdq_quad_buffer.sv
// Quad buffer and fetch control. Holds the PC and the current quad,
// requests a quad whenever the buffer is empty, and keeps the request
// level with a stable address until the memory answers.
// Assumes the memory answers each request exactly once.
module fdq_quad_buffer
    import fdq_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QUAD_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    input  logic              advance,
    input  logic              flush,
    input  logic [PC_W-1:0]   pc_next,
    output logic              mem_req,
    output logic [PC_W-SLOT_W-1:0] mem_addr,
    output logic              have,
    output logic [PC_W-1:0]   pc,
    output logic [QUAD_W-1:0] quad
);
    fetch_state_t state;
    logic         leave_quad;

    // the next PC lies outside the buffered quad
    assign leave_quad = pc_next[PC_W-1:SLOT_W] != pc[PC_W-1:SLOT_W];

    // fetch state, PC and quad storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_WAIT;
            pc    <= PC_W'(RESET_PC);
            quad  <= '0;
        end else begin
            case (state)
                FS_WAIT: if (mem_rvalid) begin
                    quad  <= mem_rdata;
                    state <= FS_HAVE;
                end
                FS_HAVE: if (advance) begin
                    pc <= pc_next;
                    if (flush || leave_quad) state <= FS_WAIT;
                end
                default: state <= FS_WAIT;
            endcase
        end
    end

    assign mem_req  = (state == FS_WAIT);
    assign mem_addr = pc[PC_W-1:SLOT_W];
    assign have     = (state == FS_HAVE);
endmodule

// File: rtl/fdq_decode.sv
// Instruction decoder. Splits a 16-bit word into its fields, walks the
// nested opcode tables to one operation bit, and detects illegal words.
// Pure combinational; assumes the word is valid when the caller says so.
module fdq_decode
    import fdq_pkg::*;
(
    input  logic [INS_W-1:0]   word,
    output logic [FIELD_W-1:0] f_opc,
    output logic [FIELD_W-1:0] f_a0,
    output logic [FIELD_W-1:0] f_a1,
    output logic [FIELD_W-1:0] f_a2,
    output logic [NUM_OPS-1:0] op_hot,
    output logic               bad,
    output logic               is_jrel,
    output logic               is_skipz,
    output logic               is_skipnz,
    output logic               is_jd
);
    logic [ID_W-1:0] op_id;

    // field extraction, opcode in the low nibble
    assign f_opc = word[0*FIELD_W +: FIELD_W];
    assign f_a0  = word[1*FIELD_W +: FIELD_W];
    assign f_a1  = word[2*FIELD_W +: FIELD_W];
    assign f_a2  = word[3*FIELD_W +: FIELD_W];

    // table walk and illegal-word detection
    always_comb begin
        bad   = 1'b0;
        op_id = {LVL_PRI, f_opc};
        if (word == '0) begin
            bad = 1'b1;
        end else if ((f_opc == OPC_SKIPZ || f_opc == OPC_SKIPNZ) &&
                     (f_a0 != '0 || f_a1 != '0)) begin
            bad = 1'b1;
        end else if (f_opc == OPC_ESC2) begin
            if (f_a2 == SUB2_ESC1) op_id = {LVL_ONE, f_a1};
            else                   op_id = {LVL_TWO, f_a2};
        end
    end

    // one-hot expansion of the identifier
    always_comb begin
        op_hot = '0;
        if (!bad) op_hot = {{(NUM_OPS-1){1'b0}}, 1'b1} << op_id;
    end

    assign is_jrel   = !bad && op_id == {LVL_PRI, OPC_JREL};
    assign is_skipz  = !bad && op_id == {LVL_PRI, OPC_SKIPZ};
    assign is_skipnz = !bad && op_id == {LVL_PRI, OPC_SKIPNZ};
    assign is_jd     = !bad && op_id == {LVL_ONE, SUB1_JD};
endmodule

// File: rtl/fdq_next_pc.sv
// Next-PC arithmetic: fall-through, conditional skip, zero-free relative
// jump and dynamic jump. Offsets count instructions from the following one.
module fdq_next_pc
    import fdq_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [FIELD_W-1:0] k,
    input  logic               is_jrel,
    input  logic               is_skipz,
    input  logic               is_skipnz,
    input  logic               is_jd,
    input  logic               src_zero,
    input  logic [PC_W-1:0]    dyn_target,
    output logic [PC_W-1:0]    pc_next
);
    logic [PC_W-1:0] seq;
    logic [PC_W-1:0] jrel_tgt;

    assign seq = pc + PC_W'(1);

    // relative target: positive branch above the split, negative otherwise
    always_comb begin
        if (k > JREL_SPLIT) jrel_tgt = seq + PC_W'(k) - PC_W'(JREL_BIAS_HI);
        else                jrel_tgt = seq + PC_W'(k) - PC_W'(JREL_BIAS_LO);
    end

    // select the flow change of the current instruction
    always_comb begin
        if (is_jd)                         pc_next = dyn_target;
        else if (is_jrel)                  pc_next = jrel_tgt;
        else if ((is_skipz && src_zero) ||
                 (is_skipnz && !src_zero)) pc_next = seq + PC_W'(1);
        else                               pc_next = seq;
    end
endmodule

// File: rtl/quad_fetch_decoder.sv
// Top of the packed-quad fetch-decoder. Buffers one quad, selects the
// slot addressed by the PC, decodes it and offers the next PC. A step is
// honoured only for a legal presented instruction; an illegal word or a
// marked quad traps the block until reset.
module quad_fetch_decoder
    import fdq_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int RESET_PC = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      mem_req,
    output logic [PC_W-SLOT_W-1:0]    mem_addr,
    input  logic [QUAD_W-1:0]         mem_rdata,
    input  logic                      mem_rvalid,
    input  logic                      step,
    input  logic                      src_zero,
    input  logic [PC_W-1:0]           dyn_target,
    output logic                      ins_valid,
    output logic [PC_W-1:0]           pc_cur,
    output logic [FIELD_W-1:0]        opcode,
    output logic [FIELD_W-1:0]        opnd0,
    output logic [FIELD_W-1:0]        opnd1,
    output logic [FIELD_W-1:0]        opnd2,
    output logic [2*FIELD_W-1:0]      imm8,
    output logic [NUM_OPS-1:0]        op_onehot,
    output logic                      illegal_ins,
    output logic                      illegal_quad,
    output logic [PC_W-1:0]           pc_next
);
    logic              have, advance;
    logic [QUAD_W-1:0] quad;
    logic [INS_W-1:0]  lanes [SLOTS];
    logic [INS_W-1:0]  word;
    logic [NUM_OPS-1:0] hot;
    logic              bad, is_jrel, is_skipz, is_skipnz, is_jd;

    fdq_quad_buffer #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .advance(advance), .flush(is_jd), .pc_next(pc_next),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .have(have), .pc(pc_cur), .quad(quad)
    );

    // slot lanes of the little-endian quad
    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
        assign lanes[s] = quad[s*INS_W +: INS_W];
    end
    assign word = lanes[pc_cur[SLOT_W-1:0]];

    fdq_decode u_dec (
        .word(word), .f_opc(opcode), .f_a0(opnd0), .f_a1(opnd1), .f_a2(opnd2),
        .op_hot(hot), .bad(bad), .is_jrel(is_jrel), .is_skipz(is_skipz),
        .is_skipnz(is_skipnz), .is_jd(is_jd)
    );

    fdq_next_pc #(.PC_W(PC_W)) u_npc (
        .pc(pc_cur), .k(opnd2), .is_jrel(is_jrel), .is_skipz(is_skipz),
        .is_skipnz(is_skipnz), .is_jd(is_jd), .src_zero(src_zero),
        .dyn_target(dyn_target), .pc_next(pc_next)
    );

    assign imm8         = {opnd1, opnd2};
    assign illegal_quad = have && quad[0];
    assign ins_valid    = have && !quad[0];
    assign illegal_ins  = ins_valid && bad;
    assign op_onehot    = ins_valid ? hot : '0;
    assign advance      = step && ins_valid && !bad;
endmodule

// File: rtl/fdq_checker.sv
// Property checker for quad_fetch_decoder, attached by bind.
module fdq_checker
    import fdq_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mem_req,
    input logic                   mem_rvalid,
    input logic [PC_W-SLOT_W-1:0] mem_addr,
    input logic                   step,
    input logic                   ins_valid,
    input logic                   illegal_ins,
    input logic                   illegal_quad,
    input logic [NUM_OPS-1:0]     op_onehot,
    input logic [PC_W-1:0]        pc_cur,
    input logic [PC_W-1:0]        pc_next
);
    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_onehot));

    assert_bad_nohot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_ins |-> op_onehot == '0);

    assert_quad_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_quad |-> !ins_valid && !illegal_ins);

    assert_step_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && step && !illegal_ins) |=> pc_cur == $past(pc_next));

    assert_jrel_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && op_onehot[OPC_JREL]) |-> pc_next != pc_cur + PC_W'(1));

    assert_trap_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_ins || illegal_quad) |=> $stable(pc_cur));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr));

    assert_no_issue_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ins_valid);
endmodule

bind quad_fetch_decoder fdq_checker #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
    .mem_addr(mem_addr), .step(step), .ins_valid(ins_valid),
    .illegal_ins(illegal_ins), .illegal_quad(illegal_quad),
    .op_onehot(op_onehot), .pc_cur(pc_cur), .pc_next(pc_next)
);

// File: tb/sim_quad_fetch_decoder.sv
`timescale 1ns/1ps
module sim_quad_fetch_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [13:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        step = 1'b0;
    logic        src_zero = 1'b0;
    logic [15:0] dyn_target = '0;
    logic        ins_valid;
    logic [15:0] pc_cur, pc_next;
    logic [3:0]  opcode, opnd0, opnd1, opnd2;
    logic [7:0]  imm8;
    logic [47:0] op_onehot;
    logic        illegal_ins, illegal_quad;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] prog [16];
    logic [15:0] exp_pc;
    int          lat = 0;
    int          wait_cnt = 0;

    always #4 clk = ~clk;

    quad_fetch_decoder u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .step(step),
        .src_zero(src_zero), .dyn_target(dyn_target), .ins_valid(ins_valid),
        .pc_cur(pc_cur), .opcode(opcode), .opnd0(opnd0), .opnd1(opnd1),
        .opnd2(opnd2), .imm8(imm8), .op_onehot(op_onehot),
        .illegal_ins(illegal_ins), .illegal_quad(illegal_quad), .pc_next(pc_next)
    );

    // program memory with a small random latency, mirrored every 16 quads
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            wait_cnt   <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req && !mem_rvalid) begin
                if (wait_cnt >= lat) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= prog[mem_addr[3:0]];
                    wait_cnt   <= 0;
                    lat        <= int'($urandom_range(0, 2));
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_word(input logic [15:0] pc);
        logic [63:0] q;
        q = prog[pc[5:2]];
        return q[16*int'(pc[1:0]) +: 16];
    endfunction

    // operation index per R3, -1 for an illegal word (R4, R5)
    function automatic int ref_id(input logic [15:0] w);
        if (w == 16'h0) return -1;
        if ((w[3:0] == 4'd7 || w[3:0] == 4'd8) && w[11:4] != 8'h0) return -1;
        if (w[3:0] == 4'd5) begin
            if (w[15:12] == 4'd15) return 32 + int'(w[11:8]);
            return 16 + int'(w[15:12]);
        end
        return int'(w[3:0]);
    endfunction

    function automatic logic [15:0] ref_next(input logic [15:0] pc, input logic [15:0] w,
                                             input bit z, input logic [15:0] tgt);
        int id;
        int k;
        id = ref_id(w);
        k  = int'(w[15:12]);
        if (id == 32) return tgt;
        if (id == 6) return (k > 7) ? pc + 16'd1 + 16'(k - 7) : pc + 16'd1 - 16'(9 - k);
        if ((id == 7 && z) || (id == 8 && !z)) return pc + 16'd2;
        return pc + 16'd1;
    endfunction

    function automatic logic [15:0] sanitize(input logic [15:0] w);
        logic [15:0] r;
        r = w;
        if ((r[3:0] == 4'd7 || r[3:0] == 4'd8)) r[11:4] = 8'h0;
        if (r == 16'h0) r = 16'h0010;
        return r;
    endfunction

    task automatic fill_random();
        for (int q = 0; q < 16; q++) begin
            for (int s = 0; s < 4; s++) begin
                logic [15:0] w;
                w = 16'($urandom);
                if ($urandom_range(0, 7) == 0) w = {4'hF, 4'h0, 4'($urandom), 4'h5};
                if (s == 0) w[0] = 1'b0;
                prog[q][16*s +: 16] = sanitize(w);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        exp_pc = 16'h0;
    endtask

    task automatic wait_issue();
        int guard;
        guard = 0;
        while (!ins_valid && !illegal_quad && guard < 20) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // present, check and step one instruction; reports whether it trapped
    task automatic do_step(input bit z, input logic [15:0] tgt, output bit trapped);
        logic [15:0] w, nx;
        logic [47:0] exp_hot;
        int          id;
        string       tag;
        bit          same;
        trapped = 1'b0;
        wait_issue();
        w  = ref_word(exp_pc);
        id = ref_id(w);
        chk(ins_valid == 1'b1, "R2", "issue", 64'(ins_valid), 64'd1);
        chk(pc_cur == exp_pc, "R2", "pc_cur", 64'(pc_cur), 64'(exp_pc));
        chk({opnd2, opnd1, opnd0, opcode} == w, "R1", "fields",
            64'({opnd2, opnd1, opnd0, opcode}), 64'(w));
        chk(imm8 == {w[11:8], w[15:12]}, "R1", "imm8", 64'(imm8), 64'({w[11:8], w[15:12]}));
        exp_hot = (id < 0) ? 48'h0 : (48'h1 << id);
        chk(op_onehot == exp_hot, "R3", "op_onehot", 64'(op_onehot), 64'(exp_hot));
        tag = (w[3:0] == 4'd7 || w[3:0] == 4'd8) ? "R5" : "R4";
        chk(illegal_ins == (id < 0), tag, "illegal_ins", 64'(illegal_ins), 64'(id < 0));
        src_zero   = z;
        dyn_target = tgt;
        step       = 1'b1;
        #1;
        nx = ref_next(exp_pc, w, z, tgt);
        if (id >= 0) begin
            tag = (id == 32) ? "R10" : (id == 6) ? "R9" : (id == 7 || id == 8) ? "R8" : "R7";
            chk(pc_next == nx, tag, "pc_next", 64'(pc_next), 64'(nx));
        end
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        if (id < 0) begin
            chk(pc_cur == exp_pc && illegal_ins, "R11", "trap hold pc", 64'(pc_cur), 64'(exp_pc));
            trapped = 1'b1;
            return;
        end
        same = (nx[15:2] == exp_pc[15:2]) && (id != 32);
        tag  = (id == 32) ? "R10" : "R2";
        chk(ins_valid == same, tag, "refetch behaviour", 64'(ins_valid), 64'(same));
        if (!same) chk(mem_req && mem_addr == nx[15:2], "R2", "fetch address",
                       64'(mem_addr), 64'(nx[15:2]));
        exp_pc = nx;
        if (ins_valid) chk(pc_cur == exp_pc, "R7", "pc after step", 64'(pc_cur), 64'(exp_pc));
    endtask

    task automatic run(input int n);
        bit t;
        for (int i = 0; i < n; i++) begin
            do_step(1'($urandom), 16'($urandom), t);
            if (t) break;
        end
    endtask

    initial begin
        bit t;
        void'($urandom(32'd1234));
        fill_random();
        do_reset();
        // R13: reset state
        #1;
        chk(pc_cur == 16'h0 && mem_req && mem_addr == 14'h0 && !ins_valid, "R13",
            "reset state", 64'({pc_cur, mem_req, ins_valid}), 64'({16'h0, 1'b1, 1'b0}));

        // random programs, sanitized so no trap occurs
        run(300);

        // R9: jump offsets k=8, k=15, k=7 (stays in quad)
        prog[0] = {16'hF006, 16'h0000, 16'h8006, 16'h0010};
        prog[3] = {16'h0010, 16'h0010, 16'h7006, 16'h0010};
        do_reset();
        run(6);
        // R9: k=0 goes back nine from the following instruction
        prog[0] = {16'h0010, 16'h0010, 16'h0006, 16'h0010};
        do_reset();
        do_step(1'b0, 16'h0, t);
        do_step(1'b0, 16'h0, t);
        chk(exp_pc == 16'hFFF9, "R9", "k=0 target", 64'(exp_pc), 64'hFFF9);
        run(2);

        // R8: skip polarity, taken and not taken
        prog[0] = {16'h0010, 16'h0007, 16'h0010, 16'h3008};
        prog[1] = {16'h0010, 16'h0010, 16'h0007, 16'h2008};
        do_reset();
        do_step(1'b0, 16'h0, t);   // skipnz, nonzero: taken
        do_step(1'b1, 16'h0, t);   // skipz, zero: taken
        do_step(1'b1, 16'h0, t);   // skipnz, zero: falls through
        do_step(1'b0, 16'h0, t);   // skipz, nonzero: falls through
        chk(exp_pc == 16'd6, "R8", "skip sequence end", 64'(exp_pc), 64'd6);

        // R10: dynamic jump into the same quad still refetches, then far
        prog[0] = {16'h0010, 16'hF0A5, 16'hF005, 16'h0010};
        do_reset();
        do_step(1'b0, 16'h0, t);
        do_step(1'b0, 16'h0002, t);
        do_step(1'b0, 16'h1233, t);
        run(3);

        // R3: escape tables
        prog[0] = {16'h0010, 16'hF205, 16'h3125, 16'h1000};
        do_reset();
        run(4);

        // R4: all-zero word traps, R11 step ignored
        prog[0] = 64'h0;
        do_reset();
        do_step(1'b0, 16'h0, t);
        chk(t == 1'b1, "R4", "bad word trapped", 64'(t), 64'd1);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk(pc_cur == 16'h0 && illegal_ins && op_onehot == '0, "R11", "still trapped",
            64'(pc_cur), 64'h0);

        // R5: reserved skip encoding
        prog[0] = {16'h0010, 16'h0010, 16'h0107, 16'h0010};
        do_reset();
        do_step(1'b0, 16'h0, t);
        do_step(1'b1, 16'h0, t);
        chk(t == 1'b1, "R5", "reserved skip trapped", 64'(t), 64'd1);

        // R6: marked quad is not issued
        prog[0] = {16'h0010, 16'h0010, 16'h0010, 16'h0011};
        do_reset();
        repeat (6) @(negedge clk);
        chk(illegal_quad && !ins_valid, "R6", "marked quad",
            64'({illegal_quad, ins_valid}), 64'b10);
        step = 1'b1;
        repeat (2) @(negedge clk);
        step = 1'b0;
        chk(pc_cur == 16'h0 && illegal_quad, "R11", "marked quad holds pc", 64'(pc_cur), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule